// File: doc/BRIEF.md
# Tagged Memory Write Controller

This block sits between a load/store pipeline and a small local data store. The data store keeps one validity tag for every capability-sized granule of memory. Each request gets exactly one response in the next cycle.

Plain stores write 1, 2, 4 or 8 bytes. Every plain store that is performed also clears the validity tag of the granule it lands in. Capability stores write a whole granule of data together with a caller-supplied tag bit. Both kinds of read return data and the granule's tag.

A single reservation, set by load-linked requests, gates the conditional stores. A conditional store only writes, and only touches a tag, when it succeeds. The success result comes back as a zero-extended register value.

Top module: `tagmem_wr_ctrl`

## Requirements
- R1: Every cycle with `req_valid` high produces a response in the next cycle with `rsp_valid` high. A cycle without a request produces `rsp_valid` low. The operation codes are: 0 load, 1 load-linked, 2 store, 3 conditional store, 4 capability load, 5 capability load-linked, 6 capability store, 7 capability conditional store.
- R2: A performed plain store writes the following data and clears the granule's tag to 0.
  - Size code s (0..3) selects 2^s bytes.
  - The bytes are taken from the low bytes of `req_wdata`, least significant byte at `req_addr` and the rest at ascending addresses.
  - The granule index is `req_addr` with its low log2(CAP_BYTES) bits dropped.
- R3: A plain store (op 2 or 3) whose bytes would cross an 8-byte-aligned word boundary sets `rsp_err`. Such a store writes nothing, changes no tag, leaves the reservation as it was, and returns a success value of 0.
- R4: A capability store writes all CAP_BYTES bytes of `req_wdata` into the addressed granule and sets its tag to `req_wtag`. A capability load returns the whole granule in `rsp_data` and its tag in `rsp_tag`. For both, the low address bits inside the granule are ignored.
- R5: A plain load returns, in the low 64 bits of `rsp_data`, the 8-byte-aligned word that contains `req_addr`. The upper bits of `rsp_data` are zero. `rsp_tag` carries the tag of the enclosing granule.
- R6: A load-linked request (op 1 or 5) sets the reservation on the addressed granule, and `link_held` reads 1 from the next cycle on.
- R7: A conditional store issued while the reservation is clear fails. It writes no data, changes no tag, and returns `rsp_success` = 0.
- R8: A conditional store issued while the reservation is set and not in error succeeds. It does the same as its unconditional form, including the tag update. It returns `rsp_success` = 1, zero-extended to REG_W bits, and clears the reservation.
- R9: Any performed store to the reserved granule clears the reservation. Stores to other granules, and stores in error, leave it unchanged.
- R10: After reset all tags read 0, `link_held` is 0 and `rsp_valid` is 0. Reset is released synchronously, two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (R1) |
| req_size | input | 2 | log2 of plain store size in bytes |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | CAP_BYTES*8 | Store data; plain stores use the low bytes |
| req_wtag | input | 1 | Tag bit for capability stores |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | CAP_BYTES*8 | Read data, zero for stores |
| rsp_tag | output | 1 | Granule tag for reads, zero for stores |
| rsp_success | output | REG_W | Conditional store result, zero-extended |
| rsp_err | output | 1 | Plain store crossed a word boundary |
| link_held | output | 1 | Reservation is set |

## Verification
The bench builds the block with a 10-bit byte address, 32-byte granules and a 64-bit register width. That gives only 32 granules. Random addresses therefore land on the reserved granule often, and plain stores keep hitting granules that capability stores have just tagged. Both reservation clearing and tag clearing are exercised heavily, not just in the directed cases. Every byte offset inside a word is reachable for each size, so all crossing and non-crossing store shapes occur.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;

  typedef enum logic [2:0] {
    OP_LOAD           = 3'd0,
    OP_LOAD_LINK      = 3'd1,
    OP_STORE          = 3'd2,
    OP_STORE_COND     = 3'd3,
    OP_CAP_LOAD       = 3'd4,
    OP_CAP_LOAD_LINK  = 3'd5,
    OP_CAP_STORE      = 3'd6,
    OP_CAP_STORE_COND = 3'd7
  } tm_op_e;

  function automatic logic op_cap(input tm_op_e op);
    return op[2];
  endfunction

  function automatic logic op_store(input tm_op_e op);
    return op[1];
  endfunction

  function automatic logic op_variant(input tm_op_e op);
    return op[0];
  endfunction

endpackage

// File: rtl/tagmem_decode.sv
module tagmem_decode
  import tagmem_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int CAP_BYTES  = 32,
  parameter int WORD_BYTES = 8
) (
  input  tm_op_e                           op_i,
  input  logic [1:0]                       size_i,
  input  logic [ADDR_W-1:0]                addr_i,
  output logic [ADDR_W-$clog2(CAP_BYTES)-1:0] gran_o,
  output logic [$clog2(CAP_BYTES)-1:0]     gran_off_o,
  output logic [CAP_BYTES-1:0]             byte_en_o,
  output logic                             cross_err_o,
  output logic                             is_cap_o,
  output logic                             is_store_o,
  output logic                             is_cond_o,
  output logic                             is_link_o
);
  localparam int GRAN_LSB = $clog2(CAP_BYTES);
  localparam int WOFF_W   = $clog2(WORD_BYTES);

  logic [3:0]        nbytes;
  logic [WOFF_W-1:0] word_off;

  always_comb begin
    nbytes      = 4'd1 << size_i;
    word_off    = addr_i[WOFF_W-1:0];
    gran_o      = addr_i[ADDR_W-1:GRAN_LSB];
    gran_off_o  = addr_i[GRAN_LSB-1:0];
    is_cap_o    = op_cap(op_i);
    is_store_o  = op_store(op_i);
    is_cond_o   = op_store(op_i) & op_variant(op_i);
    is_link_o   = ~op_store(op_i) & op_variant(op_i);
    cross_err_o = is_store_o & ~is_cap_o &
                  ((int'(word_off) + int'(nbytes)) > WORD_BYTES);
  end

  for (genvar k = 0; k < CAP_BYTES; k++) begin : g_be
    always_comb begin
      byte_en_o[k] = is_cap_o |
                     ((k >= int'(gran_off_o)) && (k < int'(gran_off_o) + int'(nbytes)));
    end
  end

endmodule

// File: rtl/tagmem_link.sv
module tagmem_link #(
  parameter int GRAN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic [GRAN_W-1:0] set_gran_i,
  input  logic              cond_done_i,
  input  logic              wr_i,
  input  logic [GRAN_W-1:0] wr_gran_i,
  output logic              link_o,
  output logic [GRAN_W-1:0] gran_o
);
  logic              link_q, link_d;
  logic [GRAN_W-1:0] gran_q, gran_d;

  always_comb begin
    link_d = link_q;
    gran_d = gran_q;
    if (set_i) begin
      link_d = 1'b1;
      gran_d = set_gran_i;
    end else if (cond_done_i || (wr_i && wr_gran_i == gran_q)) begin
      link_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      gran_q <= '0;
    end else begin
      link_q <= link_d;
      gran_q <= gran_d;
    end
  end

  assign link_o = link_q;
  assign gran_o = gran_q;

  assert_link_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> link_q);
  assert_link_hit_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && wr_i && link_q && wr_gran_i == gran_q) |=> !link_q);
  assert_link_cond_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && cond_done_i) |=> !link_q);

endmodule

// File: rtl/tagmem_store.sv
module tagmem_store #(
  parameter int GRAN_W    = 5,
  parameter int CAP_BYTES = 32,
  parameter int TAG_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [GRAN_W-1:0]      rd_gran_i,
  output logic [CAP_BYTES*8-1:0] rd_data_o,
  output logic                   rd_tag_o,
  input  logic                   wr_en_i,
  input  logic [GRAN_W-1:0]      wr_gran_i,
  input  logic [CAP_BYTES-1:0]   wr_be_i,
  input  logic [CAP_BYTES*8-1:0] wr_data_i,
  input  logic                   wr_tag_i
);
  localparam int NGRAN = 1 << GRAN_W;

  logic [7:0]       dmem    [NGRAN][CAP_BYTES];
  logic [TAG_W-1:0] tag_ram [NGRAN];
  logic [TAG_W-1:0] tag_entry;

  for (genvar b = 0; b < CAP_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en_i && wr_be_i[b]) begin
        dmem[wr_gran_i][b] <= wr_data_i[8*b +: 8];
      end
    end
    assign rd_data_o[8*b +: 8] = dmem[rd_gran_i][b];
  end

  always_comb begin
    tag_entry = '0;
    tag_entry[0] = wr_tag_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NGRAN; g++) tag_ram[g] <= '0;
    end else if (wr_en_i) begin
      tag_ram[wr_gran_i] <= tag_entry;
    end
  end

  assign rd_tag_o = tag_ram[rd_gran_i][0];

  assert_tag_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (tag_ram[$past(wr_gran_i)][0] == $past(wr_tag_i)));
  assert_tag_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (tag_ram[$past(wr_gran_i)][TAG_W-1:1] == '0));

endmodule

// File: rtl/tagmem_wr_ctrl.sv
module tagmem_wr_ctrl
  import tagmem_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int CAP_BYTES = 32,
  parameter int REG_W     = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [2:0]             req_op,
  input  logic [1:0]             req_size,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [CAP_BYTES*8-1:0] req_wdata,
  input  logic                   req_wtag,
  output logic                   rsp_valid,
  output logic [CAP_BYTES*8-1:0] rsp_data,
  output logic                   rsp_tag,
  output logic [REG_W-1:0]       rsp_success,
  output logic                   rsp_err,
  output logic                   link_held
);
  localparam int CAP_W      = CAP_BYTES * 8;
  localparam int WORD_BYTES = REG_W / 8;
  localparam int GRAN_LSB   = $clog2(CAP_BYTES);
  localparam int GRAN_W     = ADDR_W - GRAN_LSB;
  localparam int WOFF_W     = $clog2(WORD_BYTES);
  localparam int WIDX_W     = (GRAN_LSB > WOFF_W) ? GRAN_LSB - WOFF_W : 1;

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  tm_op_e                op;
  logic [GRAN_W-1:0]     gran;
  logic [GRAN_LSB-1:0]   gran_off;
  logic [CAP_BYTES-1:0]  byte_en;
  logic                  cross_err, is_cap, is_store, is_cond, is_link;
  logic                  link_q;
  logic [GRAN_W-1:0]     link_gran;
  logic [CAP_W-1:0]      rd_data;
  logic                  rd_tag;

  assign op = tm_op_e'(req_op);

  tagmem_decode #(
    .ADDR_W(ADDR_W), .CAP_BYTES(CAP_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_decode (
    .op_i(op), .size_i(req_size), .addr_i(req_addr),
    .gran_o(gran), .gran_off_o(gran_off), .byte_en_o(byte_en),
    .cross_err_o(cross_err), .is_cap_o(is_cap), .is_store_o(is_store),
    .is_cond_o(is_cond), .is_link_o(is_link)
  );

  logic             do_write, cond_ok, ll_set;
  logic [CAP_W-1:0] wr_data;
  logic             wr_tag;

  always_comb begin
    cond_ok  = is_cond & link_q & ~cross_err;
    do_write = req_valid & is_store & ~cross_err & (~is_cond | link_q);
    ll_set   = req_valid & is_link;
    wr_tag   = is_cap & req_wtag;
    if (is_cap) wr_data = req_wdata;
    else        wr_data = CAP_W'(req_wdata[REG_W-1:0]) << (8 * int'(gran_off));
  end

  tagmem_link #(.GRAN_W(GRAN_W)) u_link (
    .clk(clk), .rst_n(rst_q),
    .set_i(ll_set), .set_gran_i(gran),
    .cond_done_i(req_valid & cond_ok),
    .wr_i(do_write), .wr_gran_i(gran),
    .link_o(link_q), .gran_o(link_gran)
  );

  tagmem_store #(.GRAN_W(GRAN_W), .CAP_BYTES(CAP_BYTES), .TAG_W(8)) u_store (
    .clk(clk), .rst_n(rst_q),
    .rd_gran_i(gran), .rd_data_o(rd_data), .rd_tag_o(rd_tag),
    .wr_en_i(do_write), .wr_gran_i(gran), .wr_be_i(byte_en),
    .wr_data_i(wr_data), .wr_tag_i(wr_tag)
  );

  // response path
  logic              valid_q;
  logic [CAP_W-1:0]  data_d, data_q;
  logic              tag_d, tag_q;
  logic              succ_d, succ_q;
  logic              err_q;
  logic [WIDX_W-1:0] word_idx;

  always_comb begin
    word_idx = (GRAN_LSB > WOFF_W) ? WIDX_W'(gran_off >> WOFF_W) : '0;
    data_d   = '0;
    tag_d    = 1'b0;
    if (!is_store) begin
      tag_d = rd_tag;
      if (is_cap) data_d = rd_data;
      else        data_d = CAP_W'(rd_data[REG_W*int'(word_idx) +: REG_W]);
    end
    succ_d = is_store & cond_ok;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      tag_q   <= 1'b0;
      succ_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        data_q <= data_d;
        tag_q  <= tag_d;
        succ_q <= succ_d;
        err_q  <= cross_err;
      end
    end
  end

  assign rsp_valid   = valid_q;
  assign rsp_data    = data_q;
  assign rsp_tag     = tag_q;
  assign rsp_success = REG_W'(succ_q);
  assign rsp_err     = err_q;
  assign link_held   = link_q;

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid |=> rsp_valid);
  assert_no_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_q)
    !req_valid |=> !rsp_valid);
  assert_err_fails_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (rsp_valid && rsp_err) |-> (rsp_success == '0));
  assert_err_keeps_link_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && cross_err) |=> (link_held == $past(link_held)));
  assert_cond_idle_fail_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && is_cond && !link_held) |=> (rsp_success == '0));
  assert_success_zext_R8: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_valid |-> (rsp_success[REG_W-1:1] == '0));
  assert_load_link_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && is_link) |=> (link_held && link_gran == $past(gran)));

endmodule

// File: tb/tagmem_wr_ctrl_tb.sv
`timescale 1ns/1ps
module tagmem_wr_ctrl_tb;
  localparam int ADDR_W = 10;
  localparam int CAP_BYTES = 32;
  localparam int REG_W = 64;
  localparam int CAP_W = CAP_BYTES * 8;
  localparam int NGRAN = (1 << ADDR_W) / CAP_BYTES;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [2:0] req_op;
  logic [1:0] req_size;
  logic [ADDR_W-1:0] req_addr;
  logic [CAP_W-1:0] req_wdata;
  logic req_wtag;
  logic rsp_valid, rsp_tag, rsp_err, link_held;
  logic [CAP_W-1:0] rsp_data;
  logic [REG_W-1:0] rsp_success;

  always #10 clk = ~clk;

  tagmem_wr_ctrl #(.ADDR_W(ADDR_W), .CAP_BYTES(CAP_BYTES), .REG_W(REG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wtag(req_wtag), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_tag(rsp_tag), .rsp_success(rsp_success), .rsp_err(rsp_err),
    .link_held(link_held)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] mbytes [1 << ADDR_W];
  logic       mtag   [NGRAN];
  logic       mlink;
  int         mlgran;

  task automatic check(input string req, input string what,
                       input logic [CAP_W-1:0] act, input logic [CAP_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_cross(input logic [2:0] op, input int size, input int addr);
    return op[1] && !op[2] && (((addr % 8) + (1 << size)) > 8);
  endfunction

  task automatic run(input logic [2:0] op, input int size, input int addr,
                     input logic [CAP_W-1:0] wdata, input logic wtag);
    int gran, nb, base;
    logic st, cap, cond, ll, err, perf;
    logic [CAP_W-1:0] ed;
    logic et;
    logic [REG_W-1:0] es;
    string tagr;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_size = 2'(size);
    req_addr = ADDR_W'(addr); req_wdata = wdata; req_wtag = wtag;
    gran = addr / CAP_BYTES; nb = 1 << size;
    st = op[1]; cap = op[2]; cond = st & op[0]; ll = !st & op[0];
    err = exp_cross(op, size, addr);
    ed = '0; et = 1'b0; es = '0; perf = 1'b0;
    if (!st) begin
      tagr = cap ? "R4" : "R5";
      if (ll) tagr = "R6";
      if (cap) for (int b = 0; b < CAP_BYTES; b++) ed[8*b +: 8] = mbytes[gran*CAP_BYTES + b];
      else begin
        base = addr - (addr % 8);
        for (int b = 0; b < 8; b++) ed[8*b +: 8] = mbytes[base + b];
      end
      et = mtag[gran];
      if (ll) begin mlink = 1'b1; mlgran = gran; end
    end else begin
      if (err) tagr = "R3";
      else if (cond && !mlink) tagr = "R7";
      else if (cond) tagr = "R8";
      else tagr = cap ? "R4" : "R2";
      perf = !err && (!cond || mlink);
      if (perf) begin
        if (cap) begin
          for (int b = 0; b < CAP_BYTES; b++) mbytes[gran*CAP_BYTES + b] = wdata[8*b +: 8];
          mtag[gran] = wtag;
        end else begin
          for (int b = 0; b < nb; b++) mbytes[addr + b] = wdata[8*b +: 8];
          mtag[gran] = 1'b0;
        end
        if (cond) begin es = 1; mlink = 1'b0; end
        if (gran == mlgran) mlink = 1'b0;
      end
    end
    @(posedge clk);
    #2;
    req_valid = 1'b0;
    check("R1", "rsp_valid", CAP_W'(rsp_valid), CAP_W'(1'b1));
    check(tagr, "rsp_data", rsp_data, ed);
    check(tagr, "rsp_tag", CAP_W'(rsp_tag), CAP_W'(et));
    check(tagr, "rsp_success", CAP_W'(rsp_success), CAP_W'(es));
    check("R3", "rsp_err", CAP_W'(rsp_err), CAP_W'(err));
    check("R9", "link_held", CAP_W'(link_held), CAP_W'(mlink));
  endtask

  function automatic logic [CAP_W-1:0] rnd_wide();
    logic [CAP_W-1:0] v;
    for (int i = 0; i < CAP_W / 32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_7a61));
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_size = '0;
    req_addr = '0; req_wdata = '0; req_wtag = 1'b0;
    mlink = 1'b0; mlgran = 0;
    for (int g = 0; g < NGRAN; g++) mtag[g] = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "rsp_valid in reset", CAP_W'(rsp_valid), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "rsp_valid idle", CAP_W'(rsp_valid), '0);
    check("R10", "link_held", CAP_W'(link_held), '0);
    // R10: every tag reads zero after reset
    for (int g = 0; g < NGRAN; g++) run(3'd4, 0, g * CAP_BYTES, '0, 1'b0);
    // fill memory with tagged capabilities (R4)
    for (int g = 0; g < NGRAN; g++) run(3'd6, 0, g * CAP_BYTES + (g % 32), rnd_wide(), 1'b1);
    // R2: byte store clears a tag, other sizes and offsets
    run(3'd2, 0, 37, rnd_wide(), 1'b0);
    run(3'd4, 0, 32, '0, 1'b0);
    run(3'd2, 1, 70, rnd_wide(), 1'b0);
    run(3'd2, 2, 100, rnd_wide(), 1'b0);
    run(3'd2, 3, 136, rnd_wide(), 1'b0);
    run(3'd0, 0, 139, '0, 1'b0);
    // R3: crossing stores
    run(3'd2, 3, 165, rnd_wide(), 1'b0);
    run(3'd2, 1, 199, rnd_wide(), 1'b0);
    run(3'd4, 0, 192, '0, 1'b0);
    // R7: conditional without reservation
    run(3'd3, 0, 224, rnd_wide(), 1'b0);
    run(3'd7, 0, 256, rnd_wide(), 1'b0);
    // R6/R9: other-granule store keeps link, cond store succeeds (R8)
    run(3'd1, 0, 300, '0, 1'b0);
    run(3'd2, 0, 400, rnd_wide(), 1'b0);
    run(3'd3, 2, 292, rnd_wide(), 1'b0);
    run(3'd4, 0, 288, '0, 1'b0);
    // R9: store to reserved granule clears link
    run(3'd5, 0, 320, '0, 1'b0);
    run(3'd6, 0, 330, rnd_wide(), 1'b1);
    run(3'd7, 0, 320, rnd_wide(), 1'b0);
    // R8: capability cond store sets tag; R3 error keeps link
    run(3'd1, 0, 352, '0, 1'b0);
    run(3'd3, 3, 355, rnd_wide(), 1'b0);
    run(3'd7, 0, 359, rnd_wide(), 1'b1);
    run(3'd4, 0, 352, '0, 1'b0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      run(3'($urandom % 8), int'($urandom % 4), int'($urandom % (1 << ADDR_W)),
          rnd_wide(), 1'($urandom));
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule